// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is one stage of a synchronous binary up-counter. Every state bit changes on the same rising clock edge. A stage can be loaded in parallel from a data word, cleared at once by an active-low asynchronous clear, or advanced by one. It advances only when two separate active-high enables are both high. The stage width is a parameter, and the default is four bits.

The stage drives a terminal-count flag. The flag is high when the state is all ones and the chain enable is high. The count enable does not gate the flag. To build a wider counter, tie every count enable to one shared enable. Then drive the chain enable of each stage from the terminal-count flag of the stage below it. This chain needs no glue logic. The flag is combinational, so a stage sees its carry-in within the same cycle.

Top module: `casc_counter`

## Requirements
- R1: While clr_n is low, q is all zeros, and it reaches zero without waiting for a clock edge.
- R2: Clear overrides every other input: a rising edge while clr_n is low leaves q at zero even with load_n low or both enables high.
- R3: With clr_n high and load_n low at a rising edge, q takes d, whatever the levels of cnt_en and chain_en.
- R4: With clr_n and load_n high and both cnt_en and chain_en high at a rising edge, q becomes q plus one.
- R5: With clr_n and load_n high and either cnt_en or chain_en low at a rising edge, q keeps its value.
- R6: Counting wraps: an enabled increment from all ones gives all zeros.
- R7: tc is high exactly when chain_en is high and q is all ones. It does not depend on cnt_en, and it follows chain_en within the same cycle.
- R8: Three stages, with shared count enable, load and clear and each chain_en driven by the tc of the stage below, behave as one 12-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable that does not gate tc |
| chain_en | input | 1 | Count enable that also gates tc (carry-in of a chain) |
| d | input | WIDTH | Parallel load value |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count: chain_en high and q all ones |

## Verification
The assertions check the edge-by-edge rules on every clocked cycle while clear is inactive. These rules are: load takes d, an enabled count adds one, a missing enable holds, and an asserted tc with an enabled count leads to zero. Some behaviours show only in the bench scenarios. These are: q falling to zero in the middle of a cycle when clear drops, clear winning over a concurrent load, and tc following chain_en between clock edges. Carry rippling correctly through three chained stages is also shown only by the bench, which compares the chain against a 12-bit reference counter across loads, holds, wraps and clears in the middle of a count.

// File: rtl/casc_cnt_pkg.sv
// Package: types shared by the counter stage.
// Assumes: nothing; defines the per-edge action selected by the controller.
package casc_cnt_pkg;

    // Action the state register takes at the next rising edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_LOAD = 2'd2
    } cnt_act_e;

endpackage

// File: rtl/casc_cnt_ctrl.sv
// Module: casc_cnt_ctrl
// Picks the synchronous action of a counter stage from its control inputs.
// Assumes: asynchronous clear is handled in the state register, so only
// load, increment and hold are ranked here (load over increment over hold).
module casc_cnt_ctrl
    import casc_cnt_pkg::*;
(
    input  logic     load_n,
    input  logic     cnt_en,
    input  logic     chain_en,
    output cnt_act_e act
);

    // Rank the synchronous actions: load, then increment, then hold
    always_comb begin
        if (!load_n) begin
            act = ACT_LOAD;
        end else if (cnt_en && chain_en) begin
            act = ACT_INC;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/casc_cnt_core.sv
// Module: casc_cnt_core
// State register of one stage with its next-value logic.
// Assumes: act is stable before the rising edge; clr_n low clears the state
// at once, independent of the clock.
module casc_cnt_core
    import casc_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_act_e         act,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] q_nxt;

    // Next state for the selected action; increment wraps naturally
    always_comb begin
        unique case (act)
            ACT_LOAD: q_nxt = d;
            ACT_INC:  q_nxt = q + ONE;
            default:  q_nxt = q;
        endcase
    end

    // All state bits update together; clear acts without a clock edge
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

    AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!clr_n)
        act == ACT_LOAD |=> q == $past(d)); // R3

    AST_INC_ADDS_ONE: assert property (@(posedge clk) disable iff (!clr_n)
        act == ACT_INC |=> q == $past(q) + ONE); // R4

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clr_n)
        act == ACT_HOLD |=> $stable(q)); // R5

endmodule

// File: rtl/casc_cnt_tc.sv
// Module: casc_cnt_tc
// Terminal-count detector: flags the all-ones state qualified by chain_en.
// Assumes: purely combinational, so the flag tracks chain_en in the same cycle.
module casc_cnt_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             tc
);

    logic [WIDTH-1:0] ones_so_far;

    // Build the all-ones detect as a chain of per-bit terms
    for (genvar i = 0; i < WIDTH; i++) begin : g_ones
        if (i == 0) begin : g_first
            assign ones_so_far[i] = q[i];
        end else begin : g_next
            assign ones_so_far[i] = ones_so_far[i-1] & q[i];
        end
    end

    // Gate the detect with the chain enable only
    always_comb begin
        tc = chain_en & ones_so_far[WIDTH-1];
    end

endmodule

// File: rtl/casc_counter.sv
// Module: casc_counter
// One cascadable stage of a presettable synchronous binary up-counter.
// Assumes: in a chain, cnt_en is shared and chain_en comes from the tc of
// the stage below; clr_n is the block's asynchronous clear.
module casc_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             tc
);

    import casc_cnt_pkg::*;

    cnt_act_e act;

    casc_cnt_ctrl u_ctrl (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .act      (act)
    );

    casc_cnt_core #(.WIDTH(WIDTH)) u_core (
        .clk   (clk),
        .clr_n (clr_n),
        .act   (act),
        .d     (d),
        .q     (q)
    );

    casc_cnt_tc #(.WIDTH(WIDTH)) u_tc (
        .q        (q),
        .chain_en (chain_en),
        .tc       (tc)
    );

    AST_TC_THEN_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        tc && cnt_en && load_n |=> q == '0); // R6

endmodule

// File: tb/tb_casc_counter.sv
`timescale 1ns/100ps
// Bench: three stages chained into a 12-bit counter, scored against a model.
module tb_casc_counter;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        clr_n   = 1'b0;
    logic        clr_req = 1'b0;
    logic        load_n  = 1'b1;
    logic        en_p    = 1'b0;
    logic        en_t    = 1'b0;
    logic [11:0] d       = '0;

    logic [3:0] q0, q1, q2;
    logic       tc0, tc1, tc2;

    casc_counter #(.WIDTH(4)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en_p),
        .chain_en(en_t), .d(d[3:0]), .q(q0), .tc(tc0));
    casc_counter #(.WIDTH(4)) u_mid (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en_p),
        .chain_en(tc0), .d(d[7:4]), .q(q1), .tc(tc1));
    casc_counter #(.WIDTH(4)) u_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en_p),
        .chain_en(tc1), .d(d[11:8]), .q(q2), .tc(tc2));

    logic [11:0] qall;
    assign qall = {q2, q1, q0};

    typedef struct {
        logic [11:0] q;
        logic        tc;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [11:0] model = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual tc,q=%h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and queue the expected result
    task automatic step(input bit ld, input bit p, input bit t,
                        input logic [11:0] dv, input string tag);
        @(negedge clk);
        clr_n  = clr_req;
        load_n = !ld;
        en_p   = p;
        en_t   = t;
        d      = dv;
        if (!clr_n)      model = '0;
        else if (ld)     model = dv;
        else if (p && t) model = model + 12'd1;
        sb.push_back('{model, t && (model == 12'hFFF), tag});
    endtask

    // Drop clear in the middle of a cycle and look at q before any edge
    task automatic async_clear();
        @(posedge clk);
        #3;
        clr_n   = 1'b0;
        clr_req = 1'b0;
        #0.5;
        check(qall == 12'h000, "R1", {tc2, qall}, 13'h0);
        model = '0;
    endtask

    // tc must follow chain_en between edges while q is all ones
    task automatic tc_follow();
        @(posedge clk);
        #3;
        en_t = 1'b0;
        #0.5;
        check(tc2 == 1'b0, "R7", {tc2, qall}, {1'b0, 12'hFFF});
        en_t = 1'b1;
        #0.3;
        check(tc2 == 1'b1, "R7", {tc2, qall}, {1'b1, 12'hFFF});
    endtask

    // Monitor: compare each result after the edge that produced it
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(qall == e.q && tc2 == e.tc, e.tag, {tc2, qall}, {e.tc, e.q});
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state and R2 clear beating load and count
        step(0, 1, 1, 12'h000, "R1");
        step(0, 1, 1, 12'h000, "R1");
        step(1, 1, 1, 12'h5A5, "R2");
        clr_req = 1'b1;
        // R4 plain counting
        for (int i = 0; i < 20; i++) step(0, 1, 1, 12'h000, "R4");
        // R3 load regardless of enables
        step(1, 0, 0, 12'h0F0, "R3");
        step(1, 1, 1, 12'h123, "R3");
        step(1, 0, 1, 12'hABC, "R3");
        // R5 hold with either enable low
        for (int i = 0; i < 3; i++) step(0, 0, 1, 12'h000, "R5");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 12'h000, "R5");
        // R8 carries crossing stage boundaries
        step(1, 0, 0, 12'h0FD, "R8");
        for (int i = 0; i < 5; i++) step(0, 1, 1, 12'h000, "R8");
        // R6 wrap through all ones
        step(1, 0, 0, 12'hFFC, "R6");
        for (int i = 0; i < 8; i++) step(0, 1, 1, 12'h000, "R6");
        // R7 tc high while cnt_en low, then tracks chain_en mid-cycle
        step(1, 0, 1, 12'hFFF, "R7");
        step(0, 0, 1, 12'h000, "R7");
        tc_follow();
        // R1 / R2 clear in the middle of a count
        step(1, 0, 0, 12'h3AB, "R3");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 12'h000, "R4");
        async_clear();
        step(1, 1, 1, 12'h777, "R2");
        step(0, 1, 1, 12'h000, "R2");
        clr_req = 1'b1;
        for (int i = 0; i < 5; i++) step(0, 1, 1, 12'h000, "R1");
        // R8 long mixed run against the 12-bit model
        for (int i = 0; i < 5000; i++) begin
            if (i % 97 == 0)     step(1, 1, 1, 12'(i * 37), "R8");
            else if (i % 13 == 0) step(0, 0, 1, 12'h000, "R8");
            else if (i % 11 == 0) step(0, 1, 0, 12'h000, "R8");
            else                  step(0, 1, 1, 12'h000, "R8");
        end
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule